// File: doc/BRIEF.md
# UART Baud Divisor and Interrupt Enable Unit

This unit is the slice of a 16550-style serial port that holds the baud divisor, produces the 16x oversampling tick, keeps the interrupt enables and ranks the pending interrupt sources into one request and one identification code. Software reaches it through a simple register bus with a byte address, a write strobe, write data and combinational read data. A divisor-select input, which is driven from the line-control logic elsewhere, decides whether offset 0x4 reaches the interrupt enables or the upper divisor byte. It also decides whether offset 0x0 reaches the lower divisor byte.

The serial shifters feed five raw event levels into the unit: line error, receive data ready, character timeout, transmitter empty and modem change. The unit masks them with the enables and reports the highest ranked one. The baud tick drives the shifters elsewhere in the port.

Top module: `uart_baud_irq_unit`

## Requirements
- R1: With div_sel=0, a write to offset 0x4 stores wdata[3:0] as the four enable bits. A read of offset 0x4 returns them in bits 3:0, with every other bit 0.
- R2: With div_sel=1, offset 0x4 reads and writes the upper divisor byte in bits 7:0. The enable bits stay unchanged.
- R3: With div_sel=1, offset 0x0 reads and writes the lower divisor byte in bits 7:0. With div_sel=0, a write to offset 0x0 changes nothing and a read of offset 0x0 returns 0.
- R4: After reset, all stored bits are 0. Read data bits 31:8 are always 0, whatever was written to them.
- R5: With divisor D = upper*256 + lower and D nonzero, baud_tick is a one-cycle pulse that repeats every D clocks.
- R6: When D is 0, baud_tick stays low.
- R7: A write to either divisor byte restarts the tick generator. The first tick is registered on the (8+D)-th rising edge after the write edge, so no tick appears for at least 8 clocks.
- R8: Enable bit 0 gates both receive data ready and character timeout. Bit 1 gates transmitter empty, bit 2 gates line error and bit 3 gates modem change. A disabled source never affects irq_id.
- R9: Among the enabled pending sources, irq_id reports the one with the highest rank. The ranking and codes, from highest to lowest, are: line error 0x6, receive data 0x4, character timeout 0xC, transmitter empty 0x2, modem change 0x0.
- R10: When receive data ready and character timeout are both pending and enabled, the receive data code 0x4 wins.
- R11: With nothing enabled and pending, irq_id is 0x1. irq is high exactly when irq_id is not 0x1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_addr | input | 4 | byte offset of the access |
| bus_we | input | 1 | write strobe, one write per high cycle |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | combinational read data for bus_addr |
| div_sel | input | 1 | divisor-select bit from line control |
| ev_line_err | input | 1 | receiver line error pending |
| ev_rx_ready | input | 1 | receive data available |
| ev_rx_tmo | input | 1 | character timeout pending |
| ev_tx_empty | input | 1 | transmit holding register empty |
| ev_modem | input | 1 | modem status change pending |
| baud_tick | output | 1 | 16x baud pulse |
| irq | output | 1 | interrupt request |
| irq_id | output | 4 | interrupt identification code |

## Verification
irq_id and irq follow the event inputs and the enables in the same cycle. The checks therefore change the events at a falling edge and sample 1 ns later. A register write lands on the rising edge of its write cycle, and a readback is sampled after that edge. After a divisor write, the bench counts falling edges from the write edge. The first tick is due at the falling edge that follows the (8+D)-th rising edge. Each later tick is due exactly D falling edges after the one before it, so every measured gap and the tick count over a fixed window are compared against values computed from D.

// File: rtl/uart_bi_pkg.sv
package uart_bi_pkg;

   localparam int NUM_SRC = 5;
   localparam int IEN_W   = 4;

   // enable bits: [3] modem, [2] line error, [1] tx empty, [0] rx data/timeout
   typedef struct packed {
      logic modem;
      logic line;
      logic txe;
      logic rxd;
   } ien_t;

   typedef enum logic [3:0] {
      IID_MODEM = 4'h0,
      IID_NONE  = 4'h1,
      IID_TXE   = 4'h2,
      IID_RXD   = 4'h4,
      IID_LINE  = 4'h6,
      IID_TMO   = 4'hC
   } iid_e;

   // rank 0 is the most urgent source
   function automatic iid_e rank_code(input int rank);
      case (rank)
         0:       return IID_LINE;
         1:       return IID_RXD;
         2:       return IID_TMO;
         3:       return IID_TXE;
         default: return IID_MODEM;
      endcase
   endfunction

endpackage

// File: rtl/uart_bi_regs.sv
module uart_bi_regs
   import uart_bi_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              div_sel,
   output logic [DATA_W-1:0] rdata,
   output ien_t              ien,
   output logic [BYTE_W-1:0] div_hi,
   output logic [BYTE_W-1:0] div_lo,
   output logic              div_wr
);

   localparam logic [ADDR_W-1:0] OFF_LO  = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] OFF_SHR = ADDR_W'(4);

   generate
      if (DATA_W < BYTE_W) begin : g_bad_data
         $error("uart_bi_regs: DATA_W must hold one divisor byte");
      end
      if (BYTE_W < IEN_W) begin : g_bad_byte
         $error("uart_bi_regs: BYTE_W must hold the enable bits");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("uart_bi_regs: ADDR_W must reach offset 4");
      end
   endgenerate

   logic hit_lo, hit_shr;
   logic wr_lo, wr_hi, wr_ien;

   assign hit_lo  = (addr == OFF_LO);
   assign hit_shr = (addr == OFF_SHR);
   assign wr_lo   = we & hit_lo  &  div_sel;
   assign wr_hi   = we & hit_shr &  div_sel;
   assign wr_ien  = we & hit_shr & ~div_sel;
   assign div_wr  = wr_lo | wr_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien    <= '0;
         div_hi <= '0;
         div_lo <= '0;
      end else begin
         if (wr_ien) ien    <= ien_t'(wdata[IEN_W-1:0]);
         if (wr_hi)  div_hi <= wdata[BYTE_W-1:0];
         if (wr_lo)  div_lo <= wdata[BYTE_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (hit_shr) begin
         if (div_sel) rdata[BYTE_W-1:0] = div_hi;
         else         rdata[IEN_W-1:0]  = ien;
      end else if (hit_lo && div_sel) begin
         rdata[BYTE_W-1:0] = div_lo;
      end
   end

   // R2
   ien_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && div_sel && hit_shr) |=> $stable(ien));

   // R3
   lo_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !div_sel && hit_lo) |=> $stable(div_lo));

endmodule

// File: rtl/uart_bi_baud.sv
module uart_bi_baud #(
   parameter int DIV_W    = 16,
   parameter int HOLD_CYC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   input  logic             reload,
   output logic             tick
);

   generate
      if (DIV_W < 2) begin : g_bad_div
         $error("uart_bi_baud: DIV_W too small");
      end
      if (HOLD_CYC < 0) begin : g_bad_hold
         $error("uart_bi_baud: HOLD_CYC must not be negative");
      end
   endgenerate

   logic             hold_busy;
   logic [DIV_W-1:0] cnt;

   generate
      if (HOLD_CYC > 0) begin : g_hold
         localparam int HOLD_W = $clog2(HOLD_CYC + 1);
         logic [HOLD_W-1:0] hold;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           hold <= '0;
            else if (reload)      hold <= HOLD_W'(HOLD_CYC);
            else if (hold != '0)  hold <= hold - 1'b1;
         end

         assign hold_busy = (hold != '0);

         // R7
         hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hold != '0) |=> !tick);
      end else begin : g_nohold
         assign hold_busy = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (reload || hold_busy || divisor == '0) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt >= divisor - 1'b1) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end

   // R6
   zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (divisor == '0) |=> !tick);

   // R5
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && divisor > DIV_W'(1) && !reload) |=> !tick);

endmodule

// File: rtl/uart_bi_prio.sv
module uart_bi_prio
   import uart_bi_pkg::*;
#(
   parameter bit HAS_TMO = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  ien_t       ien,
   input  logic       ev_line_err,
   input  logic       ev_rx_ready,
   input  logic       ev_rx_tmo,
   input  logic       ev_tx_empty,
   input  logic       ev_modem,
   output logic [3:0] irq_id,
   output logic       irq
);

   logic [NUM_SRC-1:0] pend;
   logic               tmo_pend;

   generate
      if (HAS_TMO) begin : g_tmo
         assign tmo_pend = ev_rx_tmo & ien.rxd;
      end else begin : g_no_tmo
         assign tmo_pend = 1'b0;
      end
   endgenerate

   // index equals rank, 0 most urgent
   assign pend[0] = ev_line_err & ien.line;
   assign pend[1] = ev_rx_ready & ien.rxd;
   assign pend[2] = tmo_pend;
   assign pend[3] = ev_tx_empty & ien.txe;
   assign pend[4] = ev_modem    & ien.modem;

   always_comb begin
      irq_id = IID_NONE;
      for (int r = NUM_SRC - 1; r >= 0; r--) begin
         if (pend[r]) irq_id = rank_code(r);
      end
   end

   assign irq = |pend;

   // R11
   irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (irq_id != IID_NONE));

   // R9
   line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_line_err && ien.line) |-> (irq_id == IID_LINE));

   // R8
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ien == '0) |-> !irq);

endmodule

// File: rtl/uart_baud_irq_unit.sv
module uart_baud_irq_unit
   import uart_bi_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 4,
   parameter int BYTE_W   = 8,
   parameter int HOLD_CYC = 8,
   parameter bit HAS_TMO  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              div_sel,
   input  logic              ev_line_err,
   input  logic              ev_rx_ready,
   input  logic              ev_rx_tmo,
   input  logic              ev_tx_empty,
   input  logic              ev_modem,
   output logic              baud_tick,
   output logic              irq,
   output logic [3:0]        irq_id
);

   localparam int DIV_W = 2 * BYTE_W;

   ien_t              ien;
   logic [BYTE_W-1:0] div_hi, div_lo;
   logic              div_wr;

   uart_bi_regs #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .BYTE_W (BYTE_W)
   ) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (bus_addr),
      .we      (bus_we),
      .wdata   (bus_wdata),
      .div_sel (div_sel),
      .rdata   (bus_rdata),
      .ien     (ien),
      .div_hi  (div_hi),
      .div_lo  (div_lo),
      .div_wr  (div_wr)
   );

   uart_bi_baud #(
      .DIV_W    (DIV_W),
      .HOLD_CYC (HOLD_CYC)
   ) i_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .divisor ({div_hi, div_lo}),
      .reload  (div_wr),
      .tick    (baud_tick)
   );

   uart_bi_prio #(
      .HAS_TMO (HAS_TMO)
   ) i_prio (
      .clk         (clk),
      .rst_n       (rst_n),
      .ien         (ien),
      .ev_line_err (ev_line_err),
      .ev_rx_ready (ev_rx_ready),
      .ev_rx_tmo   (ev_rx_tmo),
      .ev_tx_empty (ev_tx_empty),
      .ev_modem    (ev_modem),
      .irq_id      (irq_id),
      .irq         (irq)
   );

   // R4
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-1:BYTE_W] == '0);

endmodule

// File: tb/test_uart_baud_irq_unit.sv
module test_uart_baud_irq_unit;

   localparam int HOLD = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        div_sel = 1'b0;
   logic        ev_line_err = 1'b0, ev_rx_ready = 1'b0, ev_rx_tmo = 1'b0;
   logic        ev_tx_empty = 1'b0, ev_modem = 1'b0;
   logic        baud_tick, irq;
   logic [3:0]  irq_id;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   uart_baud_irq_unit i_uart_baud_irq_unit (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .div_sel(div_sel),
      .ev_line_err(ev_line_err), .ev_rx_ready(ev_rx_ready), .ev_rx_tmo(ev_rx_tmo),
      .ev_tx_empty(ev_tx_empty), .ev_modem(ev_modem),
      .baud_tick(baud_tick), .irq(irq), .irq_id(irq_id)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // expected code from enables {modem,line,txe,rxd} and events
   function automatic logic [3:0] exp_id(input logic [3:0] en, input logic le,
      input logic rx, input logic tmo, input logic tx, input logic md);
      if (le && en[2])  return 4'h6;
      if (rx && en[0])  return 4'h4;
      if (tmo && en[0]) return 4'hC;
      if (tx && en[1])  return 4'h2;
      if (md && en[3])  return 4'h0;
      return 4'h1;
   endfunction

   task automatic bus_write(input logic dsel, input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      div_sel = dsel; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      #1 bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic dsel, input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      div_sel = dsel; bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic set_events(input logic [4:0] e);
      @(negedge clk);
      {ev_modem, ev_tx_empty, ev_rx_tmo, ev_rx_ready, ev_line_err} = e;
      #1;
   endtask

   // lo_last: write the upper byte first and the lower byte last
   task automatic baud_check(input int d, input bit lo_last);
      int first, prev, nt, lim;
      bit gap_ok;
      if (lo_last) begin
         bus_write(1'b1, 4'h4, 32'(d >> 8));
         bus_write(1'b1, 4'h0, 32'(d & 8'hFF));
      end else begin
         bus_write(1'b1, 4'h0, 32'(d & 8'hFF));
         bus_write(1'b1, 4'h4, 32'(d >> 8));
      end
      first = -1; prev = 0; nt = 0; gap_ok = 1'b1;
      lim = (d == 0) ? 300 : HOLD + 1 + 4 * d;
      for (int k = 1; k <= lim; k++) begin
         @(negedge clk);
         if (baud_tick) begin
            if (first < 0) first = k;
            else if (k - prev != d) gap_ok = 1'b0;
            prev = k;
            nt++;
         end
      end
      if (d == 0) begin
         check("R6 ticks with zero divisor", 32'(nt), 32'd0);
      end else begin
         check("R7 first tick position", 32'(first), 32'(HOLD + 1 + d));
         check("R5 tick spacing", 32'(gap_ok), 32'd1);
         check("R5 tick count", 32'(nt), 32'd4);
      end
   endtask

   initial begin
      #(4 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      logic [3:0]  en;
      logic [4:0]  ev;
      void'($urandom(32'd20241));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R4: reset state
      bus_read(1'b0, 4'h4, rd); check("R4 enables after reset", rd, 32'h0);
      bus_read(1'b1, 4'h4, rd); check("R4 upper divisor after reset", rd, 32'h0);
      bus_read(1'b1, 4'h0, rd); check("R4 lower divisor after reset", rd, 32'h0);
      check("R11 idle code after reset", 32'(irq_id), 32'h1);
      check("R11 no irq after reset", 32'(irq), 32'h0);
      check("R6 no tick after reset", 32'(baud_tick), 32'h0);

      // R1 and R4: enables with reserved bits written
      bus_write(1'b0, 4'h4, 32'hFFFF_FFF5);
      bus_read(1'b0, 4'h4, rd); check("R1 R4 enable readback", rd, 32'h5);

      // R2: upper divisor byte leaves enables alone
      bus_write(1'b1, 4'h4, 32'hFFFF_FFA3);
      bus_read(1'b1, 4'h4, rd); check("R2 upper byte readback", rd, 32'hA3);
      bus_read(1'b0, 4'h4, rd); check("R2 enables unchanged", rd, 32'h5);

      // R3: lower byte, and offset 0 ignored without div_sel
      bus_write(1'b1, 4'h0, 32'h0000_013C);
      bus_read(1'b1, 4'h0, rd); check("R3 lower byte readback", rd, 32'h3C);
      bus_write(1'b0, 4'h0, 32'h0000_0077);
      bus_read(1'b0, 4'h0, rd); check("R3 offset 0 reads zero", rd, 32'h0);
      bus_read(1'b1, 4'h0, rd); check("R3 lower byte not overwritten", rd, 32'h3C);

      // R10: receive data beats timeout
      bus_write(1'b0, 4'h4, 32'h1);
      set_events(5'b00110); check("R10 rx over timeout", 32'(irq_id), 32'h4);
      set_events(5'b00100); check("R10 timeout alone", 32'(irq_id), 32'hC);
      // R8: all pending, nothing enabled
      bus_write(1'b0, 4'h4, 32'h0);
      set_events(5'b11111); check("R8 masked sources", 32'(irq_id), 32'h1);
      check("R11 masked irq low", 32'(irq), 32'h0);
      // R9: full ranking walk
      bus_write(1'b0, 4'h4, 32'hF);
      set_events(5'b11111); check("R9 line error first", 32'(irq_id), 32'h6);
      set_events(5'b11000); check("R9 tx over modem", 32'(irq_id), 32'h2);
      set_events(5'b10000); check("R9 modem last", 32'(irq_id), 32'h0);

      // R8 R9 R11: random enables and events
      for (int i = 0; i < 150; i++) begin
         en = 4'($urandom);
         ev = 5'($urandom);
         bus_write(1'b0, 4'h4, {$urandom} & 32'hFFFF_FFF0 | 32'(en));
         bus_read(1'b0, 4'h4, rd);
         check("R1 random enable readback", rd, 32'(en));
         set_events(ev);
         check("R9 random code", 32'(irq_id),
            32'(exp_id(en, ev[0], ev[1], ev[2], ev[3], ev[4])));
         check("R11 random irq", 32'(irq),
            32'(exp_id(en, ev[0], ev[1], ev[2], ev[3], ev[4]) != 4'h1));
      end
      set_events(5'b00000);

      // R5 R6 R7: baud generator
      baud_check(1, 1'b1);
      baud_check(3, 1'b0);
      baud_check(258, 1'b1);
      baud_check(0, 1'b1);
      for (int i = 0; i < 4; i++) begin
         baud_check(2 + int'($urandom % 19), i[0]);
      end

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule